// File: doc/BRIEF.md
# Serial Flash Quad-Mode Bring-Up Sequencer

This block takes an external serial NOR flash from its power-up state, where every command travels on a single data line, into four-line command mode. It finishes by leaving the flash in continuous quad-read streaming, so later reads can skip the instruction phase. It drives a downstream command-sequencer request port. Each request carries an opcode, a lane-width flag, and optional address, alternate-byte, write-data and read-data phases. The request is held until the sequencer accepts it. The block then waits for a completion response before it moves on.

After each write-type command, the block reads the flash status register over and over until the busy bit clears. Each of these poll steps has its own cycle limit. If a flash never goes idle, the block raises an error and stops. A strap input is sampled when the run is started. When set, it adds a read-parameter command and its poll, which are needed when the serial clock runs at its fastest rate. When the streaming read has been accepted, a done flag rises and stays high until reset.

Top module: `qmode_bringup`

## Requirements
- R1: After reset the block issues no request and holds done and err low. It stays that way until start is seen high at a clock edge.
- R2: Once req_valid is high, it stays high and every request field stays unchanged until req_ready is sampled high. The only exception is a poll timeout.
- R3: The command order is as follows:
  - 0x06, then a poll.
  - 0x31 carrying data 0x02 (bit QE_BIT=1 set), then a poll.
  - 0x38, then a poll.
  - An optional read-parameter pair (see R5).
  - 0xEB last.
  
  req_quad is 0 (one line for every phase) for every command up to and including 0x38 and its poll's predecessors. It is 1 (four lines for every phase) for every later command. Any address, alternate or write-data field whose enable is low reads as zero.
- R4: A poll step sends 0x05 with req_rd_en=1. It repeats 0x05 while bit 0 of the response byte is 1, and it advances as soon as bit 0 is 0, whatever the other bits are.
- R5: With the strap high at start, 0xC0 with data 0x02 and a quad poll are inserted between the post-0x38 poll and 0xEB. With the strap low, they are omitted. Strap changes after start have no effect.
- R6: The final 0xEB request has req_addr_en=1, req_addr=STREAM_ADDR, req_alt_en=1, req_alt=0xA0 and req_stream=1, and needs no response. done rises in the cycle after it is accepted and stays high until reset.
- R7: If one poll step lasts POLL_LIMIT cycles without finishing, err rises and no further request is issued. The count restarts for every poll step.
- R8: start has no effect while a run is in progress or after done or err is set.
- R9: Only one command is outstanding at a time. No new request is raised between the acceptance of a non-final command and its response.
- R10: done and err are never high together, and neither is high while a request is pending.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin the bring-up run |
| fast_strap | input | 1 | Add the read-parameter command (sampled at start) |
| req_valid | output | 1 | Command request pending |
| req_ready | input | 1 | Sequencer accepts the pending request |
| req_opcode | output | 8 | Instruction byte |
| req_quad | output | 1 | 1: four lines for all phases; 0: one line |
| req_addr_en | output | 1 | Address phase present |
| req_addr | output | ADDR_W | Address value |
| req_alt_en | output | 1 | One alternate byte present |
| req_alt | output | 8 | Alternate byte value |
| req_wr_en | output | 1 | One write-data byte present |
| req_wdata | output | 8 | Write-data byte |
| req_rd_en | output | 1 | One read-data byte expected |
| req_stream | output | 1 | Continuous read, no completion expected |
| rsp_valid | input | 1 | Completion of the accepted command |
| rsp_data | input | 8 | Read byte returned with the completion |
| done | output | 1 | Sequence completed (sticky) |
| err | output | 1 | Poll timeout (sticky) |

## Verification
The bench's flash model holds the busy bit for a chosen number of reads per poll step, and it returns an idle byte in which every bit except bit 0 is set. A design that tested the wrong bit, or the whole byte, would stall or skip polls, and the model's opcode queue would mismatch. The poll-step limit is set so that one poll step fits inside it but the sum of all poll steps does not. A timer that was never cleared between steps would then raise err on a healthy flash. A separate run flips the strap and pulses start mid-sequence. Sampling the strap live, or restarting on start, would change the command list. A flash that stays busy forever must end in err with the 0x31 command never sent.

// File: rtl/qmb_pkg.sv
package qmb_pkg;

   typedef enum logic [3:0] {
      ST_WREN    = 4'd0,
      ST_POLL_A  = 4'd1,
      ST_WRSR    = 4'd2,
      ST_POLL_B  = 4'd3,
      ST_QMODE   = 4'd4,
      ST_POLL_C  = 4'd5,
      ST_RDPARM  = 4'd6,
      ST_POLL_D  = 4'd7,
      ST_STREAM  = 4'd8
   } step_e;

   typedef enum logic [2:0] {
      F_IDLE  = 3'd0,
      F_ISSUE = 3'd1,
      F_WAIT  = 3'd2,
      F_DONE  = 3'd3,
      F_FAIL  = 3'd4
   } fsm_e;

   localparam logic [7:0] OP_WREN   = 8'h06;
   localparam logic [7:0] OP_RDSR   = 8'h05;
   localparam logic [7:0] OP_WRSR2  = 8'h31;
   localparam logic [7:0] OP_QMODE  = 8'h38;
   localparam logic [7:0] OP_RDPARM = 8'hC0;
   localparam logic [7:0] OP_QREAD  = 8'hEB;

   function automatic logic step_is_poll(step_e s);
      return (s == ST_POLL_A) || (s == ST_POLL_B) ||
             (s == ST_POLL_C) || (s == ST_POLL_D);
   endfunction

endpackage

// File: rtl/qmb_script.sv
module qmb_script
   import qmb_pkg::*;
#(
   parameter int          ADDR_W      = 24,
   parameter int          QE_BIT      = 1,
   parameter int          RP_BIT      = 1,
   parameter logic [7:0]  ALT_VALUE   = 8'hA0,
   parameter logic [ADDR_W-1:0] STREAM_ADDR = '0
) (
   input  step_e             step,
   output logic [7:0]        opcode,
   output logic              quad,
   output logic              addr_en,
   output logic [ADDR_W-1:0] addr,
   output logic              alt_en,
   output logic [7:0]        alt,
   output logic              wr_en,
   output logic [7:0]        wdata,
   output logic              rd_en,
   output logic              stream
);
   localparam logic [7:0] QE_BYTE = 8'(1) << QE_BIT;
   localparam logic [7:0] RP_BYTE = 8'(1) << RP_BIT;

   always_comb begin
      opcode  = OP_RDSR;
      quad    = (step > ST_QMODE);
      addr_en = 1'b0;
      addr    = '0;
      alt_en  = 1'b0;
      alt     = '0;
      wr_en   = 1'b0;
      wdata   = '0;
      rd_en   = 1'b0;
      stream  = 1'b0;
      unique case (step)
         ST_WREN:   opcode = OP_WREN;
         ST_WRSR: begin
            opcode = OP_WRSR2;
            wr_en  = 1'b1;
            wdata  = QE_BYTE;
         end
         ST_QMODE:  opcode = OP_QMODE;
         ST_RDPARM: begin
            opcode = OP_RDPARM;
            wr_en  = 1'b1;
            wdata  = RP_BYTE;
         end
         ST_STREAM: begin
            opcode  = OP_QREAD;
            addr_en = 1'b1;
            addr    = STREAM_ADDR;
            alt_en  = 1'b1;
            alt     = ALT_VALUE;
            stream  = 1'b1;
         end
         ST_POLL_A, ST_POLL_B, ST_POLL_C, ST_POLL_D: begin
            opcode = OP_RDSR;
            rd_en  = 1'b1;
         end
         default: opcode = OP_RDSR;
      endcase
   end
endmodule

// File: rtl/qmb_step_next.sv
module qmb_step_next
   import qmb_pkg::*;
(
   input  step_e cur,
   input  logic  use_rdparm,
   output step_e nxt
);
   always_comb begin
      nxt = step_e'(4'(cur) + 4'd1);
      if (!use_rdparm && (cur == ST_POLL_C))
         nxt = ST_STREAM;
   end
endmodule

// File: rtl/qmb_poll_timer.sv
module qmb_poll_timer #(
   parameter int LIMIT = 4096
) (
   input  logic clk,
   input  logic rst_n,
   input  logic active,
   output logic expired
);
   generate
      if (LIMIT == 0) begin : g_off
         logic unused_in;
         assign unused_in = clk ^ rst_n ^ active;
         assign expired   = 1'b0;
      end else begin : g_on
         localparam int CW = $clog2(LIMIT + 1);
         localparam logic [CW-1:0] LIM = CW'(LIMIT);
         logic [CW-1:0] cnt;
         always_ff @(posedge clk) begin
            if (!rst_n || !active)
               cnt <= '0;
            else if (cnt != LIM)
               cnt <= cnt + 1'b1;
         end
         assign expired = active && (cnt == LIM);
      end
   endgenerate
endmodule

// File: rtl/qmode_bringup.sv
module qmode_bringup
   import qmb_pkg::*;
#(
   parameter int                ADDR_W      = 24,
   parameter int                POLL_LIMIT  = 4096,
   parameter int                BUSY_BIT    = 0,
   parameter int                QE_BIT      = 1,
   parameter int                RP_BIT      = 1,
   parameter logic [7:0]        ALT_VALUE   = 8'hA0,
   parameter logic [ADDR_W-1:0] STREAM_ADDR = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              fast_strap,
   output logic              req_valid,
   input  logic              req_ready,
   output logic [7:0]        req_opcode,
   output logic              req_quad,
   output logic              req_addr_en,
   output logic [ADDR_W-1:0] req_addr,
   output logic              req_alt_en,
   output logic [7:0]        req_alt,
   output logic              req_wr_en,
   output logic [7:0]        req_wdata,
   output logic              req_rd_en,
   output logic              req_stream,
   input  logic              rsp_valid,
   input  logic [7:0]        rsp_data,
   output logic              done,
   output logic              err
);
   localparam logic [7:0] BUSY_MASK = 8'(1) << BUSY_BIT;

   generate
      if (ADDR_W < 8 || ADDR_W > 32) begin : g_bad_addr
         $error("ADDR_W must lie in 8..32");
      end
      if (BUSY_BIT < 0 || BUSY_BIT > 7) begin : g_bad_busy
         $error("BUSY_BIT must index a byte");
      end
      if (QE_BIT < 0 || QE_BIT > 7 || RP_BIT < 0 || RP_BIT > 7) begin : g_bad_bits
         $error("QE_BIT and RP_BIT must index a byte");
      end
      if (POLL_LIMIT < 0) begin : g_bad_lim
         $error("POLL_LIMIT must not be negative");
      end
   endgenerate

   fsm_e  state;
   step_e step;
   step_e step_nxt;
   logic  strap_q;
   logic  poll_active;
   logic  poll_expired;
   logic  rsp_busy;

   qmb_script #(
      .ADDR_W      (ADDR_W),
      .QE_BIT      (QE_BIT),
      .RP_BIT      (RP_BIT),
      .ALT_VALUE   (ALT_VALUE),
      .STREAM_ADDR (STREAM_ADDR)
   ) u_script (
      .step    (step),
      .opcode  (req_opcode),
      .quad    (req_quad),
      .addr_en (req_addr_en),
      .addr    (req_addr),
      .alt_en  (req_alt_en),
      .alt     (req_alt),
      .wr_en   (req_wr_en),
      .wdata   (req_wdata),
      .rd_en   (req_rd_en),
      .stream  (req_stream)
   );

   qmb_step_next u_next (
      .cur        (step),
      .use_rdparm (strap_q),
      .nxt        (step_nxt)
   );

   assign poll_active = ((state == F_ISSUE) || (state == F_WAIT)) && step_is_poll(step);

   qmb_poll_timer #(
      .LIMIT (POLL_LIMIT)
   ) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .active  (poll_active),
      .expired (poll_expired)
   );

   assign rsp_busy = |(rsp_data & BUSY_MASK);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state   <= F_IDLE;
         step    <= ST_WREN;
         strap_q <= 1'b0;
      end else begin
         unique case (state)
            F_IDLE: begin
               if (start) begin
                  state   <= F_ISSUE;
                  step    <= ST_WREN;
                  strap_q <= fast_strap;
               end
            end
            F_ISSUE: begin
               if (poll_expired)
                  state <= F_FAIL;
               else if (req_ready)
                  state <= (step == ST_STREAM) ? F_DONE : F_WAIT;
            end
            F_WAIT: begin
               if (poll_expired) begin
                  state <= F_FAIL;
               end else if (rsp_valid) begin
                  state <= F_ISSUE;
                  if (!(step_is_poll(step) && rsp_busy))
                     step <= step_nxt;
               end
            end
            F_DONE:  state <= F_DONE;
            F_FAIL:  state <= F_FAIL;
            default: state <= F_IDLE;
         endcase
      end
   end

   assign req_valid = (state == F_ISSUE);
   assign done      = (state == F_DONE);
   assign err       = (state == F_FAIL);

endmodule

// File: rtl/qmode_bringup_chk.sv
module qmode_bringup_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       req_valid,
   input logic       req_ready,
   input logic [7:0] req_opcode,
   input logic       req_quad,
   input logic       req_addr_en,
   input logic       req_alt_en,
   input logic       req_wr_en,
   input logic [7:0] req_wdata,
   input logic       req_rd_en,
   input logic       req_stream,
   input logic       done,
   input logic       err
);
   // R2
   req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_ready) |=>
         ((req_valid && $stable(req_opcode) && $stable(req_wdata) && $stable(req_quad)) || err));

   // R6
   done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> done);

   // R10
   flag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done || err) |-> $onehot0({done, err, req_valid}));

   // R7
   err_halts_chk: assert property (@(posedge clk) disable iff (!rst_n)
      err |=> (err && !req_valid));

   // R3
   single_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && (req_opcode == 8'h06 || req_opcode == 8'h31 || req_opcode == 8'h38))
         |-> !req_quad);

   // R6
   stream_form_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_stream) |->
         (req_quad && req_addr_en && req_alt_en && req_opcode == 8'hEB));

   // R4
   poll_form_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_opcode == 8'h05) |-> (req_rd_en && !req_wr_en && !req_stream));
endmodule

bind qmode_bringup qmode_bringup_chk u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .req_valid   (req_valid),
   .req_ready   (req_ready),
   .req_opcode  (req_opcode),
   .req_quad    (req_quad),
   .req_addr_en (req_addr_en),
   .req_alt_en  (req_alt_en),
   .req_wr_en   (req_wr_en),
   .req_wdata   (req_wdata),
   .req_rd_en   (req_rd_en),
   .req_stream  (req_stream),
   .done        (done),
   .err         (err)
);

// File: tb/qmode_bringup_test.sv
module qmode_bringup_test;
   localparam int CLK_PERIOD = 10;
   localparam int LIMIT      = 48;
   localparam int READY_GAP  = 1;
   localparam int RSP_GAP    = 2;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic        fast_strap = 1'b0;
   logic        req_valid;
   logic        req_ready;
   logic [7:0]  req_opcode;
   logic        req_quad;
   logic        req_addr_en;
   logic [23:0] req_addr;
   logic        req_alt_en;
   logic [7:0]  req_alt;
   logic        req_wr_en;
   logic [7:0]  req_wdata;
   logic        req_rd_en;
   logic        req_stream;
   logic        rsp_valid;
   logic [7:0]  rsp_data;
   logic        done;
   logic        err;

   int errs = 0;
   int checks = 0;
   bit exp_done = 1'b0;
   bit stuck = 1'b0;
   int busy_per_poll = 0;
   int poll_left = 0;
   logic [53:0] exp_q[$];

   always #(CLK_PERIOD/2) clk = ~clk;

   qmode_bringup #(.POLL_LIMIT(LIMIT)) uut (
      .clk(clk), .rst_n(rst_n), .start(start), .fast_strap(fast_strap),
      .req_valid(req_valid), .req_ready(req_ready), .req_opcode(req_opcode),
      .req_quad(req_quad), .req_addr_en(req_addr_en), .req_addr(req_addr),
      .req_alt_en(req_alt_en), .req_alt(req_alt), .req_wr_en(req_wr_en),
      .req_wdata(req_wdata), .req_rd_en(req_rd_en), .req_stream(req_stream),
      .rsp_valid(rsp_valid), .rsp_data(rsp_data), .done(done), .err(err)
   );

   task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] expv);
      checks++;
      if (!ok) begin
         errs++;
         $display("FAIL %s actual=%h expected=%h at %0t", req, act, expv, $time);
      end
   endtask

   function automatic logic [53:0] mk(input logic [7:0] op, input logic q, input logic ae,
                                      input logic le, input logic [7:0] lv, input logic we,
                                      input logic [7:0] wd, input logic re, input logic st,
                                      input logic [23:0] ad);
      return {op, q, ae, le, lv, we, wd, re, st, ad};
   endfunction

   function automatic logic [53:0] poll_cmd(input logic q);
      return mk(8'h05, q, 0, 0, 8'h00, 0, 8'h00, 1, 0, 24'h0);
   endfunction

   // flash and command-sequencer model
   initial begin
      logic [53:0] cur;
      logic [53:0] e;
      bit is_rd;
      bit is_st;
      req_ready = 1'b0;
      rsp_valid = 1'b0;
      rsp_data  = 8'h00;
      forever begin
         @(negedge clk);
         if (rst_n && req_valid) begin
            repeat (READY_GAP) @(negedge clk);
            if (req_valid) begin
               cur = {req_opcode, req_quad, req_addr_en, req_alt_en, req_alt, req_wr_en,
                      req_wdata, req_rd_en, req_stream, req_addr};
               is_rd = (req_opcode == 8'h05);
               is_st = req_stream;
               if (exp_q.size() == 0) begin
                  chk(1'b0, "R3 extra command", 64'(cur), 64'h0);
               end else begin
                  e = exp_q.pop_front();
                  chk(cur == e, "R3/R4/R5/R6 command", 64'(cur), 64'(e));
               end
               req_ready = 1'b1;
               @(negedge clk);
               req_ready = 1'b0;
               if (is_st) begin
                  exp_done = 1'b1;
               end else begin
                  if (!is_rd) poll_left = busy_per_poll;
                  repeat (RSP_GAP) begin
                     chk(req_valid == 1'b0, "R9 outstanding", 64'(req_valid), 64'h0);
                     @(negedge clk);
                  end
                  rsp_valid = 1'b1;
                  if (is_rd && (stuck || poll_left > 0)) rsp_data = 8'h01;
                  else if (is_rd) rsp_data = 8'hFE;
                  else rsp_data = 8'h5A;
                  if (is_rd && poll_left > 0) poll_left--;
                  @(negedge clk);
                  rsp_valid = 1'b0;
               end
            end
         end
      end
   end

   // per-clock reference comparison
   initial begin
      forever begin
         @(negedge clk);
         #1;
         if (rst_n) begin
            chk(done == exp_done, "R6 done timing", 64'(done), 64'(exp_done));
            chk(!(done && err), "R10 exclusive", 64'({done, err}), 64'h0);
            if (!stuck) chk(err == 1'b0, "R7 no false timeout", 64'(err), 64'h0);
         end
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      errs++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end

   task automatic do_reset();
      rst_n = 1'b0;
      start = 1'b0;
      exp_done = 1'b0;
      repeat (4) @(negedge clk);
      exp_q.delete();
      rst_n = 1'b1;
   endtask

   task automatic pulse_start(input bit strap);
      fast_strap = strap;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
   endtask

   task automatic check_quiet(input string req);
      for (int i = 0; i < 20; i++) begin
         @(negedge clk);
         chk(req_valid == 1'b0, req, 64'(req_valid), 64'h0);
      end
   endtask

   task automatic run_seq(input int b, input bit strap, input bit disturb);
      do_reset();
      stuck = 1'b0;
      busy_per_poll = b;
      exp_q.push_back(mk(8'h06, 0, 0, 0, 8'h00, 0, 8'h00, 0, 0, 24'h0));
      for (int i = 0; i <= b; i++) exp_q.push_back(poll_cmd(1'b0));
      exp_q.push_back(mk(8'h31, 0, 0, 0, 8'h00, 1, 8'h02, 0, 0, 24'h0));
      for (int i = 0; i <= b; i++) exp_q.push_back(poll_cmd(1'b0));
      exp_q.push_back(mk(8'h38, 0, 0, 0, 8'h00, 0, 8'h00, 0, 0, 24'h0));
      for (int i = 0; i <= b; i++) exp_q.push_back(poll_cmd(1'b1));
      if (strap) begin
         exp_q.push_back(mk(8'hC0, 1, 0, 0, 8'h00, 1, 8'h02, 0, 0, 24'h0));
         for (int i = 0; i <= b; i++) exp_q.push_back(poll_cmd(1'b1));
      end
      exp_q.push_back(mk(8'hEB, 1, 1, 1, 8'hA0, 0, 8'h00, 0, 1, 24'h0));
      @(negedge clk);
      pulse_start(strap);
      if (disturb) begin
         repeat (12) @(negedge clk);
         // R8 and R5: restart attempt and strap flip mid-run
         pulse_start(!strap);
      end
      for (int i = 0; i < 1500 && !done; i++) @(negedge clk);
      chk(done == 1'b1, "R6 done reached", 64'(done), 64'h1);
      chk(exp_q.size() == 0, "R3 all commands seen", 64'(exp_q.size()), 64'h0);
      pulse_start(strap);
      check_quiet("R8 start after done");
      chk(done == 1'b1, "R6 done sticky", 64'(done), 64'h1);
   endtask

   initial begin
      do_reset();
      // R1: idle after reset without start
      for (int i = 0; i < 10; i++) begin
         @(negedge clk);
         chk(req_valid == 1'b0, "R1 no request", 64'(req_valid), 64'h0);
         chk(done == 1'b0 && err == 1'b0, "R1 flags low", 64'({done, err}), 64'h0);
      end

      run_seq(0, 1'b0, 1'b0);
      run_seq(2, 1'b1, 1'b0);
      run_seq(1, 1'b1, 1'b1);
      // R7: timer restarts per poll step; total poll time exceeds the limit
      run_seq(4, 1'b1, 1'b0);
      run_seq(3, 1'b0, 1'b1);

      // R7: flash never leaves busy
      do_reset();
      stuck = 1'b1;
      exp_q.push_back(mk(8'h06, 0, 0, 0, 8'h00, 0, 8'h00, 0, 0, 24'h0));
      for (int i = 0; i < 40; i++) exp_q.push_back(poll_cmd(1'b0));
      @(negedge clk);
      pulse_start(1'b0);
      repeat (LIMIT + 40) @(negedge clk);
      chk(err == 1'b1, "R7 timeout err", 64'(err), 64'h1);
      chk(done == 1'b0, "R7 no done", 64'(done), 64'h0);
      chk(req_valid == 1'b0, "R7 halted", 64'(req_valid), 64'h0);
      pulse_start(1'b0);
      check_quiet("R8 start after err");
      chk(err == 1'b1, "R7 err sticky", 64'(err), 64'h1);
      stuck = 1'b0;

      do_reset();
      @(negedge clk);
      #1;
      chk(done == 1'b0 && err == 1'b0, "R1 reset clears flags", 64'({done, err}), 64'h0);

      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end
endmodule